// File: doc/BRIEF.md
# Read-Enable Latency Calibration Engine

The engine sits between a memory controller and its read datapath. After memory initialization finishes, it measures how many clock cycles pass between a read command and the arrival of captured read data, separately for every data byte. It first writes a fixed training burst to the memory, then reads it back repeatedly. For each byte it steps a read-enable tap along a delay line fed by the read command until the captured burst equals the training pattern. Bytes whose data turns up sooner are delayed further, so the whole word is presented in one cycle.

When every byte has found its tap, the engine raises a ready flag and starts passing user read requests to the memory side. Each user read then produces a read-valid window of one cycle per pair of burst beats. All byte lanes of that window line up with the slowest lane. If a byte finds no match at the largest tap, the engine raises an error flag, keeps ready low and issues no further reads.

Top module: `rden_cal`

## Requirements
- R1: While rst_ni is low, cmd_wr_o, cmd_rd_o, rd_valid_o, ready_o and error_o are all 0.
- R2: No command is issued before init_done_i is high. Afterwards exactly one training write (a one-cycle cmd_wr_o pulse) is issued, and it comes before the first read.
- R3: The training burst occupies BURST_LEN/2 cycles on each byte lane. It carries 0xAA in even cycle positions (0, 2, ...) and 0x55 in odd ones. A byte matches only if every cycle of its window carries the expected value.
- R4: Every byte starts at a delay of 1 cycle, counted from the cycle cmd_rd_o is high to the first data cycle. Each calibration read that does not match raises the delay by one, so a successful calibration issues exactly max(latency) training reads.
- R5: Each byte lane searches and locks its own delay independently of the other lanes.
- R6: After ready, a read issued at cycle T delivers rd_data_o byte b in cycle T+Lmax+k with the value captured on that lane in cycle T+Lb+k. Lmax is the largest lane latency.
- R7: After ready, every read yields rd_valid_o high on all bytes for exactly BURST_LEN/2 consecutive cycles, and low otherwise.
- R8: ready_o rises when every lane has locked, and stays high until reset.
- R9: If a lane still does not match at delay MAX_DLY, error_o goes high after exactly MAX_DLY training reads. ready_o stays low, and no further reads are issued, not even for user_rd_i.
- R10: user_rd_i has no effect while ready_o is low: cmd_rd_o does not follow it and rd_valid_o stays 0.
- R11: After ready, a user_rd_i high in cycle c makes cmd_rd_o high in cycle c+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Memory initialization has finished |
| user_rd_i | input | 1 | User read request, one cycle per read |
| cap_data_i | input | NUM_BYTES*8 | Captured read data, one byte per lane per cycle |
| cmd_wr_o | output | 1 | Write command toward the memory side (training write) |
| cmd_rd_o | output | 1 | Read command toward the memory side |
| rd_data_o | output | NUM_BYTES*8 | Deskewed read data |
| rd_valid_o | output | NUM_BYTES | Per-byte read valid |
| ready_o | output | 1 | Calibration completed |
| error_o | output | 1 | Calibration failed |

## Verification
The assertions assume the following about the memory side. Every read returns its burst after a fixed latency per lane. Data from one read has left the bus before the next read is issued. The bus is idle at 0x00 outside a burst. User reads come at least a burst apart. The bench memory model keeps to these rules. It holds one fixed latency per lane for a whole run, returns the training burst only after it has seen the write, and spaces user reads well beyond the longest window. Random latencies between 1 and MAX_DLY mix with directed cases: minimum latency, maximum latency, one lane beyond the maximum, and a lane stuck at one pattern value.

// File: rtl/rden_cal_pkg.sv
package rden_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_GAP, ST_RD, ST_WAIT, ST_EVAL, ST_DONE, ST_FAIL
  } cal_st_e;

  // Training byte for a burst beat: alternating so a one-cycle slip mismatches
  function automatic logic [7:0] train_byte(input logic odd_beat);
    return odd_beat ? 8'h55 : 8'hAA;
  endfunction
endpackage

// File: rtl/rden_cal_fsm.sv
module rden_cal_fsm
  import rden_cal_pkg::*;
#(
  parameter int MAX_DLY = 16,
  parameter int BEATS   = 2,
  parameter int WR_GAP  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic all_hit_i,
  input  logic any_fail_i,
  output logic wr_o,
  output logic rd_o,
  output logic eval_o,
  output logic ready_o,
  output logic error_o
);
  localparam int WAIT_CYC = MAX_DLY + BEATS + 1;
  localparam int CW       = $clog2(WAIT_CYC + WR_GAP + 1);

  cal_st_e st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (init_done_i) st_q <= ST_WR;
        ST_WR: begin
          cnt_q <= '0;
          st_q  <= ST_GAP;
        end
        ST_GAP:
          if (cnt_q == CW'(WR_GAP - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_RD;
          end else cnt_q <= cnt_q + 1'b1;
        ST_RD: begin
          cnt_q <= '0;
          st_q  <= ST_WAIT;
        end
        ST_WAIT:
          if (cnt_q == CW'(WAIT_CYC - 1)) st_q <= ST_EVAL;
          else cnt_q <= cnt_q + 1'b1;
        ST_EVAL:
          if (any_fail_i)     st_q <= ST_FAIL;
          else if (all_hit_i) st_q <= ST_DONE;
          else                st_q <= ST_RD;
        default: st_q <= st_q;
      endcase
    end
  end

  assign wr_o    = (st_q == ST_WR);
  assign rd_o    = (st_q == ST_RD);
  assign eval_o  = (st_q == ST_EVAL);
  assign ready_o = (st_q == ST_DONE);
  assign error_o = (st_q == ST_FAIL);

  logic wr_done_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wr_done_q <= 1'b0;
    else if (wr_o) wr_done_q <= 1'b1;
  end

  AST_WR_BEFORE_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> wr_done_q);  // R2
  AST_SINGLE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o && wr_done_q);  // R2
endmodule

// File: rtl/rden_cal_lane.sv
module rden_cal_lane
  import rden_cal_pkg::*;
#(
  parameter int MAX_DLY = 16,
  parameter int DW      = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAX_DLY-1:0] en_line_i,  // bit i = read enable delayed i+1 cycles
  input  logic [7:0]         cap_i,
  input  logic               trial_start_i,
  input  logic               eval_i,
  input  logic               ready_i,
  input  logic [DW-1:0]      skew_i,
  output logic               hit_o,
  output logic               locked_o,
  output logic               at_max_o,
  output logic [DW-1:0]      dly_o,
  output logic               rd_en_o,
  output logic [7:0]         rd_byte_o
);
  localparam int DEPTH = MAX_DLY - 1;

  logic [DW-1:0] dly_q;
  logic locked_q, mis_q, odd_q, win;

  always_comb begin
    win = 1'b0;
    for (int i = 0; i < MAX_DLY; i++)
      if (dly_q == DW'(i + 1)) win = en_line_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q    <= DW'(1);
      locked_q <= 1'b0;
      mis_q    <= 1'b0;
      odd_q    <= 1'b0;
    end else begin
      odd_q <= win ? ~odd_q : 1'b0;
      if (trial_start_i) mis_q <= 1'b0;
      else if (win && !ready_i && cap_i != train_byte(odd_q)) mis_q <= 1'b1;
      if (eval_i && !locked_q) begin
        if (!mis_q) locked_q <= 1'b1;
        else if (dly_q != DW'(MAX_DLY)) dly_q <= dly_q + 1'b1;
      end
    end
  end

  assign hit_o    = ~mis_q;
  assign locked_o = locked_q;
  assign at_max_o = (dly_q == DW'(MAX_DLY));
  assign dly_o    = dly_q;

  // Deskew: delay {valid, byte} by skew_i cycles
  logic [8:0] dl_q [DEPTH];
  logic [8:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) dl_q[i] <= '0;
    end else begin
      dl_q[0] <= {win, cap_i};
      for (int i = 1; i < DEPTH; i++) dl_q[i] <= dl_q[i-1];
    end
  end

  always_comb begin
    tap = {win, cap_i};
    for (int i = 0; i < DEPTH; i++)
      if (skew_i == DW'(i + 1)) tap = dl_q[i];
  end

  assign rd_en_o   = ready_i & tap[8];
  assign rd_byte_o = tap[7:0];

  AST_DLY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_q >= DW'(1) && dly_q <= DW'(MAX_DLY));  // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q && $stable(dly_q));  // R5
endmodule

// File: rtl/rden_cal.sv
module rden_cal
  import rden_cal_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int MAX_DLY   = 16,
  parameter int BURST_LEN = 4,
  parameter int WR_GAP    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_done_i,
  input  logic                   user_rd_i,
  input  logic [NUM_BYTES*8-1:0] cap_data_i,
  output logic                   cmd_wr_o,
  output logic                   cmd_rd_o,
  output logic [NUM_BYTES*8-1:0] rd_data_o,
  output logic [NUM_BYTES-1:0]   rd_valid_o,
  output logic                   ready_o,
  output logic                   error_o
);
  localparam int BEATS = BURST_LEN / 2;
  localparam int DW    = $clog2(MAX_DLY + 1);

  logic fsm_wr, fsm_rd, eval, all_hit, any_fail;

  rden_cal_fsm #(.MAX_DLY(MAX_DLY), .BEATS(BEATS), .WR_GAP(WR_GAP)) u_fsm (
    .clk_i, .rst_ni, .init_done_i,
    .all_hit_i (all_hit),
    .any_fail_i(any_fail),
    .wr_o      (fsm_wr),
    .rd_o      (fsm_rd),
    .eval_o    (eval),
    .ready_o   (ready_o),
    .error_o   (error_o)
  );

  // Read command register and burst-wide enable line
  logic rd_q;
  logic [BEATS-2:0] hist_q;
  logic [MAX_DLY-1:0] en_line_q;
  logic line_in;

  assign line_in = rd_q | (|hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      hist_q    <= '0;
      en_line_q <= '0;
    end else begin
      rd_q         <= fsm_rd | (ready_o & user_rd_i);
      hist_q[0]    <= rd_q;
      for (int i = 1; i < BEATS - 1; i++) hist_q[i] <= hist_q[i-1];
      en_line_q[0] <= line_in;
      for (int i = 1; i < MAX_DLY; i++) en_line_q[i] <= en_line_q[i-1];
    end
  end

  assign cmd_rd_o = rd_q;
  assign cmd_wr_o = fsm_wr;

  logic [NUM_BYTES-1:0] hit, locked, at_max;
  logic [DW-1:0] dly [NUM_BYTES];
  logic [DW-1:0] max_dly;

  always_comb begin
    max_dly = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (dly[b] > max_dly) max_dly = dly[b];
  end

  assign all_hit  = &(hit | locked);
  assign any_fail = |(~hit & ~locked & at_max);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    rden_cal_lane #(.MAX_DLY(MAX_DLY), .DW(DW)) u_lane (
      .clk_i, .rst_ni,
      .en_line_i    (en_line_q),
      .cap_i        (cap_data_i[b*8 +: 8]),
      .trial_start_i(fsm_rd),
      .eval_i       (eval),
      .ready_i      (ready_o),
      .skew_i       (max_dly - dly[b]),
      .hit_o        (hit[b]),
      .locked_o     (locked[b]),
      .at_max_o     (at_max[b]),
      .dly_o        (dly[b]),
      .rd_en_o      (rd_valid_o[b]),
      .rd_byte_o    (rd_data_o[b*8 +: 8])
    );
  end

  AST_RDY_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && error_o));  // R9
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);  // R8
  AST_VALID_NEEDS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rd_valid_o |-> ready_o);  // R10
  AST_BYTES_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (rd_valid_o == '0 || rd_valid_o == '1));  // R6
  AST_NO_RD_AFTER_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !cmd_rd_o);  // R9
  AST_USER_RD_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && user_rd_i |=> cmd_rd_o);  // R11
endmodule

// File: tb/rden_cal_tb_top.sv
module rden_cal_tb_top;
  localparam int NB = 4, MAXD = 16, BL = 4, BEATS = BL / 2;

  logic clk = 1'b0, rst_ni = 1'b0, init_done_i = 1'b0, user_rd_i = 1'b0;
  logic [NB*8-1:0] cap_data_i = '0;
  logic cmd_wr_o, cmd_rd_o, ready_o, error_o;
  logic [NB*8-1:0] rd_data_o;
  logic [NB-1:0] rd_valid_o;

  rden_cal #(.NUM_BYTES(NB), .MAX_DLY(MAXD), .BURST_LEN(BL)) dut_i (
    .clk_i(clk), .rst_ni, .init_done_i, .user_rd_i, .cap_data_i,
    .cmd_wr_o, .cmd_rd_o, .rd_data_o, .rd_valid_o, .ready_o, .error_o);

  always #10 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;
  int lat [NB];
  int stuck = -1;
  int last_t = -1000, last_n = 0, user_n = 0;
  bit last_train = 0, wr_seen = 0;
  int rd_issues = 0, wr_issues = 0, first_wr = -1, first_rd = -1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] tok(int n, int k, int b);
    return 8'(n * 53 + k * 29 + b * 17 + 7);
  endfunction

  function automatic logic [7:0] pat(int k);
    return (k % 2) ? 8'h55 : 8'hAA;
  endfunction

  function automatic int lmax();
    int m = 0;
    for (int b = 0; b < NB; b++) if (lat[b] > m) m = lat[b];
    return m;
  endfunction

  // memory model: command observer
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cmd_wr_o) begin
        wr_issues++;
        wr_seen = 1;
        if (first_wr < 0) first_wr = cyc;
      end
      if (cmd_rd_o) begin
        rd_issues++;
        if (first_rd < 0) first_rd = cyc;
        last_t     = cyc;
        last_train = !ready_o;
        last_n     = user_n;
        user_n++;
      end
    end
  end

  // memory model: data return
  always @(posedge clk) begin
    #1;
    for (int b = 0; b < NB; b++) begin
      int k;
      logic [7:0] v;
      k = cyc - last_t - lat[b];
      v = 8'h00;
      if (k >= 0 && k < BEATS) begin
        if (!last_train) v = tok(last_n, k, b);
        else if (wr_seen) v = (b == stuck) ? 8'hAA : pat(k);
      end
      cap_data_i[b*8 +: 8] = v;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic user_read(input bit expect_ok);
    int t;
    @(negedge clk);
    user_rd_i = 1'b1;
    @(negedge clk);
    user_rd_i = 1'b0;
    t = cyc;
    if (expect_ok) chk(cmd_rd_o === 1'b1, "R11", "cmd_rd_o after user_rd_i", cmd_rd_o, 1);
    else           chk(cmd_rd_o === 1'b0, "R9", "cmd_rd_o after failure", cmd_rd_o, 0);
    for (int j = 0; j < MAXD + BEATS + 3; j++) begin
      int k;
      logic [NB*8-1:0] ed;
      logic [NB-1:0] ev;
      @(negedge clk);
      k = cyc - t - lmax();
      ev = (expect_ok && k >= 0 && k < BEATS) ? '1 : '0;
      chk(rd_valid_o === ev, expect_ok ? "R7" : "R9", "rd_valid_o window", rd_valid_o, ev);
      if (ev != '0) begin
        for (int b = 0; b < NB; b++) ed[b*8 +: 8] = tok(t - 0 == last_t ? last_n : last_n, k, b);
        chk(rd_data_o === ed, "R6", "deskewed data (R5 lanes)", rd_data_o, ed);
      end
    end
  endtask

  task automatic run_case(input int l [NB], input int stuck_b, input bit expect_ok);
    lat   = l;
    stuck = stuck_b;
    @(negedge clk);
    rst_ni = 1'b0; init_done_i = 1'b0; user_rd_i = 1'b0;
    @(negedge clk);
    chk({cmd_wr_o, cmd_rd_o, rd_valid_o, ready_o, error_o} === '0, "R1",
        "outputs in reset", {cmd_wr_o, cmd_rd_o, rd_valid_o, ready_o, error_o}, 0);
    last_t = -1000; last_n = 0; user_n = 0; last_train = 0; wr_seen = 0;
    rd_issues = 0; wr_issues = 0; first_wr = -1; first_rd = -1;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      user_rd_i = i[0];
      @(negedge clk);
      chk(cmd_rd_o === 1'b0 && rd_valid_o === '0, "R10", "user_rd_i before ready",
          {cmd_rd_o, rd_valid_o}, 0);
    end
    user_rd_i = 1'b0;
    chk(wr_issues == 0 && rd_issues == 0, "R2", "commands before init", wr_issues + rd_issues, 0);
    init_done_i = 1'b1;
    for (int i = 0; i < 3000 && !(ready_o || error_o); i++) @(negedge clk);
    chk(wr_issues == 1 && first_wr >= 0 && first_wr < first_rd, "R2",
        "single write before reads", wr_issues, 1);
    if (expect_ok) begin
      chk(ready_o === 1'b1 && error_o === 1'b0, "R8", "ready after lock", {ready_o, error_o}, 2);
      chk(rd_issues == lmax(), "R4", "training read count", rd_issues, lmax());
      for (int r = 0; r < 3; r++) user_read(1'b1);
      chk(ready_o === 1'b1, "R8", "ready held", ready_o, 1);
    end else begin
      chk(error_o === 1'b1 && ready_o === 1'b0, stuck_b >= 0 ? "R3" : "R9",
          "error after failed search", {ready_o, error_o}, 1);
      chk(rd_issues == MAXD, "R9", "reads before error", rd_issues, MAXD);
      user_read(1'b0);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int l [NB];
    void'($urandom(32'h1a2b3c4d));
    run_case('{1, 1, 1, 1}, -1, 1'b1);          // minimum latency
    run_case('{MAXD, 1, 7, MAXD}, -1, 1'b1);    // max latency, wide skew (R5)
    run_case('{3, MAXD + 1, 2, 2}, -1, 1'b0);   // R9 lane beyond range
    run_case('{4, 5, 6, 7}, 2, 1'b0);           // R3 stuck lane never matches
    for (int r = 0; r < 6; r++) begin
      for (int b = 0; b < NB; b++) l[b] = 1 + int'($urandom % MAXD);
      run_case(l, -1, 1'b1);
    end
    summary();
    $finish;
  end
endmodule